// File: doc/BRIEF.md
# ADC Conversion Sequencer (host side)

This block runs one conversion at a time on an external successive-approximation converter. It drives the converter's three control lines: an active-low chip select, a read/convert line and a high-byte enable. It watches the converter's ready line, which is low while a conversion runs. Once the result is ready it reads it back over a parallel bus. The read is either a single 12-bit word or two reads from an 8-bit bus.

A one-cycle start request from the host launches a fixed sequence:

1. Select the chip and hold the control lines steady for a setup interval.
2. Drive read/convert low for a bounded number of cycles.
3. Wait for the ready line to fall, then wait for it to rise again.
4. Read the result with read/convert high and chip select low.
5. Present the 12-bit sample with a one-cycle valid strobe.

If the converter never starts, or never finishes, the sequence ends with a one-cycle timeout pulse and no sample.

All intervals are counted in clock cycles and set by parameters: setup, start pulse width, wait for the ready line to fall, conversion limit and bus access.

Top module: `adc_conv_ctrl`

## Requirements
- R1: During and right after reset, cs_n=1, rc_n=1, hbe=0, sample_vld=0 and timeout_o=0.
- R2: A start_req sampled while the controller is idle and cvt_idle=1 drives cs_n low with rc_n high and hbe=0 for exactly SETUP_CYC cycles before rc_n falls.
- R3: Each low phase of rc_n lasts exactly PULSE_CYC cycles.
- R4: A start_req sampled while a sequence is in progress, or while cvt_idle=0, is dropped. It produces no rc_n falling edge, and cs_n stays high when the controller is idle.
- R5: The data bus is captured only after cvt_idle has returned to 1, with cs_n=0 and rc_n=1, ACC_CYC cycles into each read phase. Bus values outside that window never reach sample_o.
- R6: With byte_mode=0 at the start, sample_o equals data_i[11:0] from the single read.
- R7: With byte_mode=1 at the start, the first read (hbe=0) takes data_i[7:0] as sample bits 7:0. The second read (hbe=1) takes data_i[7:4] as sample bits 11:8. data_i[11:8] and, in the second read, data_i[3:0] are ignored. hbe is high only while cs_n=0 and rc_n=1.
- R8: Each completed conversion gives exactly one sample_vld pulse of one cycle, with sample_o valid in that cycle.
- R9: If cvt_idle does not fall within FALL_WIN cycles after rc_n returns high, timeout_o pulses for one cycle, no sample_vld is produced, and the controller returns to idle (cs_n=1).
- R10: If cvt_idle, after falling, stays low for CONV_TMO cycles, timeout_o pulses for one cycle, no sample_vld is produced, and the controller returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start_req | input | 1 | Request to run one conversion |
| byte_mode | input | 1 | 1: two 8-bit reads, 0: one 12-bit read (latched at start) |
| cvt_idle | input | 1 | Converter ready line, low while converting |
| data_i | input | 12 | Converter data bus |
| cs_n | output | 1 | Active-low chip select |
| rc_n | output | 1 | Read (high) / convert (low) control |
| hbe | output | 1 | High-byte enable for the second read in byte mode |
| sample_o | output | 12 | Assembled sample |
| sample_vld | output | 1 | One-cycle strobe, sample_o valid |
| timeout_o | output | 1 | One-cycle pulse when the converter fails to respond |

## Verification
The assertions assume the converter lowers its ready line only in response to a falling read/convert edge. They also assume it does not do so before the start pulse has ended, so the ready line is never low while the controller sits in setup or in the pulse. The bench's converter model keeps to this: its ready line falls a fixed 20 cycles after the falling edge, longer than the 12-cycle pulse. The model only holds the line low by itself in a test that stays away from any running sequence. The model drives a fixed junk pattern on the bus whenever the converter would not be driving it. In byte mode it also drives junk on the unused upper lines, so any capture outside the read window shows up in the sample.

// File: rtl/adc_ctrl_pkg.sv
package adc_ctrl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_START_PULSE,
    ST_WAIT_BUSY_LOW,
    ST_WAIT_BUSY_HIGH,
    ST_READ_LO,
    ST_READ_HI,
    ST_DONE
  } ctrl_state_e;
endpackage

// File: rtl/adc_ctrl_timer.sv
module adc_ctrl_timer #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (clr) cnt_d = '0;
    else     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/adc_ctrl_fsm.sv
module adc_ctrl_fsm
  import adc_ctrl_pkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 12,
  parameter int FALL_WIN  = 32,
  parameter int CONV_TMO  = 1400,
  parameter int ACC_CYC   = 4,
  parameter int CNT_W     = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic             byte_mode,
  input  logic             cvt_idle,
  input  logic [CNT_W-1:0] cnt,
  output ctrl_state_e      state,
  output logic             cnt_clr,
  output logic             cap_lo,
  output logic             cap_hi,
  output logic             word_sel,
  output logic             timeout_o
);
  localparam logic [CNT_W-1:0] SETUP_END = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_END = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] FALL_END  = CNT_W'(FALL_WIN - 1);
  localparam logic [CNT_W-1:0] CONV_END  = CNT_W'(CONV_TMO - 1);
  localparam logic [CNT_W-1:0] ACC_END   = CNT_W'(ACC_CYC - 1);

  ctrl_state_e state_q, state_d;
  logic        byte_q, byte_d;
  logic        tmo_q, tmo_d;

  always_comb begin
    state_d = state_q;
    byte_d  = byte_q;
    tmo_d   = 1'b0;
    cap_lo  = 1'b0;
    cap_hi  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_req && cvt_idle) begin
          state_d = ST_SETUP;
          byte_d  = byte_mode;
        end
      end
      ST_SETUP:       if (cnt == SETUP_END) state_d = ST_START_PULSE;
      ST_START_PULSE: if (cnt == PULSE_END) state_d = ST_WAIT_BUSY_LOW;
      ST_WAIT_BUSY_LOW: begin
        if (!cvt_idle) state_d = ST_WAIT_BUSY_HIGH;
        else if (cnt == FALL_END) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      ST_WAIT_BUSY_HIGH: begin
        if (cvt_idle) state_d = ST_READ_LO;
        else if (cnt == CONV_END) begin
          state_d = ST_IDLE;
          tmo_d   = 1'b1;
        end
      end
      ST_READ_LO: begin
        if (cnt == ACC_END) begin
          cap_lo  = 1'b1;
          state_d = byte_q ? ST_READ_HI : ST_DONE;
        end
      end
      ST_READ_HI: begin
        if (cnt == ACC_END) begin
          cap_hi  = 1'b1;
          state_d = ST_DONE;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      byte_q  <= 1'b0;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      byte_q  <= byte_d;
      tmo_q   <= tmo_d;
    end
  end

  assign state     = state_q;
  assign cnt_clr   = (state_d != state_q) || (state_q == ST_IDLE);
  assign word_sel  = !byte_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/adc_ctrl_assemble.sv
module adc_ctrl_assemble #(
  parameter int SAMPLE_W = 12,
  parameter int BYTE_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cap_lo,
  input  logic                cap_hi,
  input  logic                word_sel,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic [SAMPLE_W-1:0] sample_o
);
  localparam int HI_W = SAMPLE_W - BYTE_W;

  logic [SAMPLE_W-1:0] smp_q, smp_d;

  always_comb begin
    smp_d = smp_q;
    if (cap_lo) begin
      if (word_sel) smp_d = data_i;
      else          smp_d = {{HI_W{1'b0}}, data_i[BYTE_W-1:0]};
    end else if (cap_hi) begin
      smp_d[SAMPLE_W-1 -: HI_W] = data_i[BYTE_W-1 -: HI_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                smp_q <= '0;
    else if (cap_lo || cap_hi) smp_q <= smp_d;
  end

  assign sample_o = smp_q;
endmodule

// File: rtl/adc_conv_ctrl.sv
module adc_conv_ctrl
  import adc_ctrl_pkg::*;
#(
  parameter int SAMPLE_W  = 12,
  parameter int BYTE_W    = 8,
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 12,
  parameter int FALL_WIN  = 32,
  parameter int CONV_TMO  = 1400,
  parameter int ACC_CYC   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_req,
  input  logic                byte_mode,
  input  logic                cvt_idle,
  input  logic [SAMPLE_W-1:0] data_i,
  output logic                cs_n,
  output logic                rc_n,
  output logic                hbe,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                sample_vld,
  output logic                timeout_o
);
  localparam int MAX_A   = (SETUP_CYC > PULSE_CYC) ? SETUP_CYC : PULSE_CYC;
  localparam int MAX_B   = (FALL_WIN > ACC_CYC) ? FALL_WIN : ACC_CYC;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_LIM = (MAX_AB > CONV_TMO) ? MAX_AB : CONV_TMO;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  ctrl_state_e      state;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr, cap_lo, cap_hi, word_sel;

  adc_ctrl_timer #(.CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .cnt(cnt)
  );

  adc_ctrl_fsm #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .FALL_WIN(FALL_WIN),
    .CONV_TMO(CONV_TMO), .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
  ) fsm_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .byte_mode(byte_mode),
    .cvt_idle(cvt_idle), .cnt(cnt), .state(state), .cnt_clr(cnt_clr),
    .cap_lo(cap_lo), .cap_hi(cap_hi), .word_sel(word_sel), .timeout_o(timeout_o)
  );

  adc_ctrl_assemble #(.SAMPLE_W(SAMPLE_W), .BYTE_W(BYTE_W)) asm_i (
    .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo), .cap_hi(cap_hi),
    .word_sel(word_sel), .data_i(data_i), .sample_o(sample_o)
  );

  always_comb begin
    cs_n       = (state == ST_IDLE) || (state == ST_DONE);
    rc_n       = (state != ST_START_PULSE);
    hbe        = (state == ST_READ_HI);
    sample_vld = (state == ST_DONE);
  end
endmodule

// File: rtl/adc_conv_ctrl_chk.sv
module adc_conv_ctrl_chk #(
  parameter int SETUP_CYC = 8,
  parameter int PULSE_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic cvt_idle,
  input logic cs_n,
  input logic rc_n,
  input logic hbe,
  input logic sample_vld,
  input logic timeout_o
);
  int lo_run;
  int cs_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run <= 0;
      cs_run <= 0;
    end else begin
      lo_run <= rc_n ? 0 : lo_run + 1;
      if (cs_n)      cs_run <= 0;
      else if (rc_n) cs_run <= cs_run + 1;
    end
  end

  // R3
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rc_n) |-> (lo_run == PULSE_CYC));

  // R2
  setup_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rc_n) |-> (cs_run == SETUP_CYC) && !hbe && !cs_n);

  // R4
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cvt_idle && rc_n) |=> rc_n);

  // R7
  hbe_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hbe |-> (!cs_n && rc_n));

  // R8
  vld_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld |=> !sample_vld);

  // R9
  tmo_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!sample_vld && rc_n));

  // R10
  tmo_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o);
endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(
  .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC)
) chk_i (.*);

// File: tb/adc_conv_ctrl_tb_top.sv
module adc_conv_ctrl_tb_top;
  localparam int SETUP_CYC = 8;
  localparam int PULSE_CYC = 12;
  localparam int FALL_WIN  = 32;
  localparam int CONV_TMO  = 1400;
  localparam int ACC_CYC   = 4;
  localparam int FALL_DLY  = 20;
  localparam int CONV_CYC  = 675;

  logic        clk = 1'b0;
  logic        rst_n, start_req, byte_mode, cvt_idle;
  logic [11:0] data_i, sample_o;
  logic        cs_n, rc_n, hbe, sample_vld, timeout_o;

  always #2 clk = ~clk;

  adc_conv_ctrl #(
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC), .FALL_WIN(FALL_WIN),
    .CONV_TMO(CONV_TMO), .ACC_CYC(ACC_CYC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .byte_mode(byte_mode),
    .cvt_idle(cvt_idle), .data_i(data_i), .cs_n(cs_n), .rc_n(rc_n), .hbe(hbe),
    .sample_o(sample_o), .sample_vld(sample_vld), .timeout_o(timeout_o)
  );

  int n_run = 0, n_fail = 0;
  int n_fall = 0, n_vld = 0, n_tmo = 0;
  logic [11:0] exp_q[$];
  logic        expm_q[$];

  // converter model: 0 = never responds, 1 = normal, 2 = never finishes
  logic [11:0] m_val = 12'h000;
  logic        m_byte = 1'b0;
  int          m_resp = 1;
  logic        m_idle, ext_hold;

  assign cvt_idle = m_idle && !ext_hold;

  always_comb begin
    if (!cs_n && rc_n && cvt_idle) begin
      if (!m_byte)   data_i = m_val;
      else if (!hbe) data_i = {4'hA, m_val[7:0]};
      else           data_i = {4'h5, m_val[11:8], 4'h9};
    end else begin
      data_i = 12'h96C;
    end
  end

  initial begin
    m_idle = 1'b1;
    forever begin
      @(negedge rc_n);
      if (rst_n && !cs_n && !hbe && cvt_idle && m_resp != 0) begin
        repeat (FALL_DLY) @(posedge clk);
        m_idle <= 1'b0;
        repeat (m_resp == 2 ? CONV_TMO + 100 : CONV_CYC) @(posedge clk);
        m_idle <= 1'b1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  int   lo_run = 0, cs_run = 0;
  logic rc_prev = 1'b1, vld_prev = 1'b0, tmo_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (sample_vld) begin
        n_vld++;
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected strobe", 1, 0);
        else begin
          logic [11:0] e;
          logic        md;
          e  = exp_q.pop_front();
          md = expm_q.pop_front();
          chk(sample_o == e, md ? "R7 R5 byte sample" : "R6 R5 word sample",
              int'(sample_o), int'(e));
        end
        if (vld_prev) chk(1'b0, "R8 strobe width", 2, 1);
      end
      if (!rc_n) lo_run++;
      else begin
        if (lo_run != 0) chk(lo_run == PULSE_CYC, "R3 pulse width", lo_run, PULSE_CYC);
        lo_run = 0;
      end
      if (rc_prev && !rc_n) begin
        n_fall++;
        chk(cs_run == SETUP_CYC && !hbe, "R2 setup", cs_run, SETUP_CYC);
      end
      if (cs_n)      cs_run = 0;
      else if (rc_n) cs_run++;
      if (timeout_o) begin
        n_tmo++;
        if (tmo_prev) chk(1'b0, "R9 timeout width", 2, 1);
      end
      rc_prev  = rc_n;
      vld_prev = sample_vld;
      tmo_prev = timeout_o;
    end
  end

  task automatic run_conv(input logic [11:0] v, input logic byt, input int resp);
    m_val     = v;
    m_byte    = byt;
    m_resp    = resp;
    byte_mode = byt;
    if (resp == 1) begin
      exp_q.push_back(v);
      expm_q.push_back(byt);
    end
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    while (cs_n) @(negedge clk);
    while (!cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    int f0, t0, v0;
    rst_n = 1'b0; start_req = 1'b0; byte_mode = 1'b0; ext_hold = 1'b0;
    repeat (5) @(negedge clk);
    chk(cs_n && rc_n && !hbe && !sample_vld && !timeout_o, "R1 in reset",
        {cs_n, rc_n, hbe, sample_vld, timeout_o}, 5'b11000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && rc_n && !hbe && !sample_vld && !timeout_o, "R1 after reset",
        {cs_n, rc_n, hbe, sample_vld, timeout_o}, 5'b11000);

    // R6 word mode patterns
    run_conv(12'hA5C, 1'b0, 1);
    run_conv(12'h000, 1'b0, 1);
    run_conv(12'hFFF, 1'b0, 1);
    // R7 byte mode patterns, upper lines carry junk
    run_conv(12'h3C7, 1'b1, 1);
    run_conv(12'hFFF, 1'b1, 1);
    run_conv(12'h801, 1'b1, 1);
    run_conv(12'h0F0, 1'b1, 1);
    chk(n_vld == 7, "R8 strobe count", n_vld, 7);

    // R4: requests during a running sequence are dropped
    f0 = n_fall;
    m_val = 12'h6B2; m_byte = 1'b0; m_resp = 1; byte_mode = 1'b0;
    exp_q.push_back(12'h6B2); expm_q.push_back(1'b0);
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    for (int i = 0; i < 40; i++) begin
      repeat (9) @(negedge clk) start_req = 1'b0;
      start_req = 1'b1;
      @(negedge clk) start_req = 1'b0;
    end
    while (!cs_n) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(n_fall == f0 + 1, "R4 request during sequence", n_fall - f0, 1);

    // R4: request while converter reports busy
    ext_hold = 1'b1;
    f0 = n_fall;
    @(negedge clk) start_req = 1'b1;
    @(negedge clk) start_req = 1'b0;
    repeat (40) @(negedge clk);
    chk(n_fall == f0 && cs_n, "R4 request while busy", n_fall - f0, 0);
    ext_hold = 1'b0;
    repeat (4) @(negedge clk);

    // R9: converter never starts
    t0 = n_tmo; v0 = n_vld;
    run_conv(12'h123, 1'b0, 0);
    chk(n_tmo == t0 + 1, "R9 timeout pulse", n_tmo - t0, 1);
    chk(n_vld == v0 && cs_n, "R9 no sample, idle", n_vld - v0, 0);

    // R10: converter never finishes
    t0 = n_tmo; v0 = n_vld;
    run_conv(12'h456, 1'b1, 2);
    chk(n_tmo == t0 + 1, "R10 timeout pulse", n_tmo - t0, 1);
    chk(n_vld == v0 && cs_n, "R10 no sample, idle", n_vld - v0, 0);
    while (!cvt_idle) @(negedge clk);
    repeat (4) @(negedge clk);

    // recovery after timeouts
    run_conv(12'h9E4, 1'b1, 1);
    run_conv(12'h7A1, 1'b0, 1);
    chk(exp_q.size() == 0, "R8 all samples seen", exp_q.size(), 0);
    chk(n_vld == 10, "R8 total strobes", n_vld, 10);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule